// File: doc/BRIEF.md
# Byte-Masked Burst Write Assembler

This block is the write side of a quad-data-rate style memory together with the small read path needed to observe it. A write request, sampled with its address on a rising clock edge, opens a burst of four 18-bit data beats. The double-rate input stage is assumed to have already split each clock period into two beats: the `wa_*` inputs carry the beat of the rising half and the `wb_*` inputs carry the beat of the falling half. The beats are assembled into one 72-bit word. Only after the fourth beat has arrived is the word committed to the storage array, and only the 9-bit lanes whose enables were set are changed.

Each beat carries its own two lane enables, so any mix of 9-bit lanes over the four beats can be written. A write can be accepted at most every other clock. A read of a word that is being committed gets the new lanes merged with the stored ones, so a read issued one cycle after a write request already sees that write. Reads return data two clock edges after the request.

Top module: `qdr_wr_assembler`

## Requirements
- R1: While `rst_n` is low at a rising edge, every array word is cleared to zero and `rd_valid` goes low after that edge.
- R2: A `wr_req` sampled high at a rising edge is accepted when no write was accepted at the previous rising edge; back-to-back bursts spaced two cycles apart are both stored.
- R3: For a write accepted at edge E, beats 0 and 1 are taken from `wa_data`/`wb_data` at edge E+1 and beats 2 and 3 from the same inputs at edge E+2; beat k occupies word bits [18k+17:18k], and the word is committed at edge E+2.
- R4: A `wr_req` sampled at the rising edge right after an accepted write is ignored: its address is never written.
- R5: Lane enable bit 0 of a beat governs data bits [8:0] of that beat and bit 1 governs bits [17:9]; a lane whose enable is low keeps its stored value.
- R6: A `rd_req` sampled at edge R makes `rd_valid` high for one cycle after edge R+1, with `rd_data` holding the word at `rd_addr` as stored by then.
- R7: A read of the same address sampled one edge after a write is accepted returns the new lanes of that write merged with the old contents of the unwritten lanes.
- R8: Beat data and lane enables presented outside a burst's two data cycles are ignored and change no stored word.
- R9: A read sampled at the same edge that accepts a write to its address returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write-port select, sampled on the rising edge |
| wr_addr | input | ADDR_W | Word address of the write request |
| wa_data | input | 18 | Beat of the rising half of the cycle |
| wa_lanes | input | 2 | Lane enables for `wa_data` |
| wb_data | input | 18 | Beat of the falling half of the cycle |
| wb_lanes | input | 2 | Lane enables for `wb_data` |
| rd_req | input | 1 | Read request, sampled on the rising edge |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 72 | Read word, valid while `rd_valid` is high |
| rd_valid | output | 1 | Marks the cycle in which `rd_data` is valid |

## Verification
A wrong burst phase shows as a word whose beats are shifted or taken from the wrong cycle, or as a stray commit from idle beat inputs; the first read of that address after the faulty edge exposes it, two edges after the read request. A wrong forwarding path only shows on a read issued one edge after a write to the same address, where stale or wholly replaced lanes appear at once, so the reference model is compared every cycle under dense random traffic over four addresses to reach those collisions often.

// File: rtl/qwa_pkg.sv
// Shared constants and the write-burst phase type.
// Assumes a burst of four beats delivered two per clock period.
package qwa_pkg;

    localparam int BURST_BEATS = 4;
    localparam int EDGE_BEATS  = 2;

    // Phase of the write port between clock edges.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no burst in flight
        PH_FIRST = 2'd1,   // next edge takes beats 0 and 1
        PH_LAST  = 2'd2    // next edge takes beats 2 and 3 and commits
    } wr_phase_e;

endpackage

// File: rtl/wr_burst_ctrl.sv
// Write-burst sequencer.
// Accepts a request when no burst is waiting for its first data cycle,
// walks the two data cycles and presents the commit address.
// Assumes requests during the first data cycle are to be dropped.
module wr_burst_ctrl
    import qwa_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_phase_e         phase,
    output logic              cap_en,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr
);

    wr_phase_e         phase_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [ADDR_W-1:0] cmt_addr_q;
    logic              take_req;

    // A request is taken unless a burst awaits its first data cycle.
    always_comb begin
        take_req = wr_req && (phase_q != PH_FIRST);
    end

    // Phase register advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_FIRST: phase_q <= PH_LAST;
                default:  phase_q <= take_req ? PH_FIRST : PH_IDLE;
            endcase
        end
    end

    // Address of an accepted request, moved to the commit slot one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q <= '0;
            cmt_addr_q <= '0;
        end else begin
            if (take_req) begin
                req_addr_q <= wr_addr;
            end
            if (phase_q == PH_FIRST) begin
                cmt_addr_q <= req_addr_q;
            end
        end
    end

    assign phase       = phase_q;
    assign cap_en      = (phase_q == PH_FIRST);
    assign commit_en   = (phase_q == PH_LAST);
    assign commit_addr = cmt_addr_q;

endmodule

// File: rtl/beat_stager.sv
// Beat staging register.
// Holds the first two beats and their lane enables, then combines them
// with the two live beats into the full word and lane mask for commit.
// Assumes the live beats are valid in the cycle the commit is taken.
module beat_stager
    import qwa_pkg::*;
#(
    parameter int LANE_W         = 9,
    parameter int LANES_PER_BEAT = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         cap_en,
    input  logic [LANE_W*LANES_PER_BEAT-1:0]             wa_data,
    input  logic [LANES_PER_BEAT-1:0]                    wa_lanes,
    input  logic [LANE_W*LANES_PER_BEAT-1:0]             wb_data,
    input  logic [LANES_PER_BEAT-1:0]                    wb_lanes,
    output logic [LANE_W*LANES_PER_BEAT*BURST_BEATS-1:0] word,
    output logic [LANES_PER_BEAT*BURST_BEATS-1:0]        lanes
);

    localparam int BEAT_W  = LANE_W * LANES_PER_BEAT;
    localparam int STAGE_W = BEAT_W * EDGE_BEATS;
    localparam int STAGE_L = LANES_PER_BEAT * EDGE_BEATS;

    logic [STAGE_W-1:0] stg_data_q;
    logic [STAGE_L-1:0] stg_lanes_q;

    // Capture beats 0 and 1 in the first data cycle of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_data_q  <= '0;
            stg_lanes_q <= '0;
        end else if (cap_en) begin
            stg_data_q  <= {wb_data, wa_data};
            stg_lanes_q <= {wb_lanes, wa_lanes};
        end
    end

    // Word and lane mask in beat order, beat 0 lowest.
    always_comb begin
        word  = {wb_data, wa_data, stg_data_q};
        lanes = {wb_lanes, wa_lanes, stg_lanes_q};
    end

endmodule

// File: rtl/lane_array.sv
// Lane-writable word array with a two-edge read path.
// Writes change only enabled lanes; a read whose array access coincides
// with a commit to the same word sees the committing lanes.
// Assumes a small depth so reset can clear every word.
module lane_array #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANE_W*LANES-1:0]  wr_word,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic                     rd_req,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANE_W*LANES-1:0]  rd_data,
    output logic                     rd_valid
);

    localparam int WORD_W = LANE_W * LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              rd_pend_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] fwd_word;
    logic              addr_hit;

    // Lane-masked write, full clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem[w] <= '0;
            end
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[l]) begin
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_word[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Stored word and commit collision for the pending read.
    always_comb begin
        mem_word = mem[rd_addr_q];
        addr_hit = wr_en && (wr_addr == rd_addr_q);
    end

    // Per-lane choice between committing lane and stored lane.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_fwd
            assign fwd_word[g*LANE_W +: LANE_W] =
                (addr_hit && wr_lanes[g]) ? wr_word[g*LANE_W +: LANE_W]
                                          : mem_word[g*LANE_W +: LANE_W];
        end
    endgenerate

    // Read request stage, then registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_pend_q <= rd_req;
            rd_addr_q <= rd_addr;
            rd_valid  <= rd_pend_q;
            if (rd_pend_q) begin
                rd_data <= fwd_word;
            end
        end
    end

endmodule

// File: rtl/qdr_wr_assembler.sv
// Top of the burst write assembler.
// Joins the sequencer, the beat stager and the lane array.
// Assumes the double-rate input split has been done outside this block.
module qdr_wr_assembler
    import qwa_pkg::*;
#(
    parameter int ADDR_W         = 4,
    parameter int LANE_W         = 9,
    parameter int LANES_PER_BEAT = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_req,
    input  logic [ADDR_W-1:0]                            wr_addr,
    input  logic [LANE_W*LANES_PER_BEAT-1:0]             wa_data,
    input  logic [LANES_PER_BEAT-1:0]                    wa_lanes,
    input  logic [LANE_W*LANES_PER_BEAT-1:0]             wb_data,
    input  logic [LANES_PER_BEAT-1:0]                    wb_lanes,
    input  logic                                         rd_req,
    input  logic [ADDR_W-1:0]                            rd_addr,
    output logic [LANE_W*LANES_PER_BEAT*BURST_BEATS-1:0] rd_data,
    output logic                                         rd_valid
);

    localparam int LANES  = LANES_PER_BEAT * BURST_BEATS;
    localparam int WORD_W = LANE_W * LANES;

    wr_phase_e         phase;
    logic              cap_en;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [WORD_W-1:0] commit_word;
    logic [LANES-1:0]  commit_lanes;

    wr_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .phase       (phase),
        .cap_en      (cap_en),
        .commit_en   (commit_en),
        .commit_addr (commit_addr)
    );

    beat_stager #(.LANE_W(LANE_W), .LANES_PER_BEAT(LANES_PER_BEAT)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .wa_data  (wa_data),
        .wa_lanes (wa_lanes),
        .wb_data  (wb_data),
        .wb_lanes (wb_lanes),
        .word     (commit_word),
        .lanes    (commit_lanes)
    );

    lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit_en),
        .wr_addr  (commit_addr),
        .wr_word  (commit_word),
        .wr_lanes (commit_lanes),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/qwa_checker.sv
// Protocol checker for the burst write assembler, bound to its top.
// Assumes it observes the sequencer phase and the commit strobe.
module qwa_checker
    import qwa_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      wr_req,
    input logic      rd_req,
    input logic      rd_valid,
    input wr_phase_e phase,
    input logic      commit_en
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && phase == PH_IDLE));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && phase != PH_FIRST) |=> phase == PH_FIRST);

    // R3
    burst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FIRST |=> commit_en);

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FIRST |=> phase != PH_FIRST);

    // R6
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ##1 rd_valid);

    // R6
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> ##1 !rd_valid);

    // R8
    no_stray_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_FIRST |=> !commit_en);

endmodule

bind qdr_wr_assembler qwa_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .phase     (phase),
    .commit_en (commit_en)
);

// File: tb/sim_qdr_wr_assembler.sv
`timescale 1ns/1ps
module sim_qdr_wr_assembler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [17:0] wa_data = '0;
    logic [1:0]  wa_lanes = '0;
    logic [17:0] wb_data = '0;
    logic [1:0]  wb_lanes = '0;
    logic        rd_req = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [71:0] rd_data;
    logic        rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    qdr_wr_assembler u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wa_data(wa_data), .wa_lanes(wa_lanes), .wb_data(wb_data), .wb_lanes(wb_lanes),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Behavioural reference model
    logic [71:0] m_mem [16];
    int          m_ph = 0;
    logic [3:0]  m_addr, m_caddr, m_raddr;
    logic [35:0] m_s;
    logic [3:0]  m_sl;
    bit          m_rd1 = 1'b0;
    bit          exp_valid = 1'b0;
    logic [71:0] exp_data = '0;

    function automatic logic [71:0] lane_merge(logic [71:0] old, logic [71:0] nw, logic [7:0] en);
        logic [71:0] r = old;
        for (int i = 0; i < 8; i++) if (en[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
            m_ph = 0; m_rd1 = 0; exp_valid = 0;
        end else begin
            if (m_ph == 2)
                m_mem[m_caddr] = lane_merge(m_mem[m_caddr], {wb_data, wa_data, m_s},
                                            {wb_lanes, wa_lanes, m_sl});
            exp_valid = m_rd1;
            if (m_rd1) exp_data = m_mem[m_raddr];
            m_rd1 = rd_req; m_raddr = rd_addr;
            if (m_ph == 1) begin
                m_s = {wb_data, wa_data}; m_sl = {wb_lanes, wa_lanes};
                m_caddr = m_addr; m_ph = 2;
            end else if (wr_req) begin
                m_addr = wr_addr; m_ph = 1;
            end else m_ph = 0;
        end
    end

    // Every-cycle comparison against the model (R6 and all others in random traffic)
    always @(negedge clk) begin
        if (model_on) begin
            n_cmp++;
            if (rd_valid !== exp_valid || (exp_valid && rd_data !== exp_data)) begin
                n_bad++;
                $display("FAIL R6/model t=%0t valid=%b data=%h exp valid=%b data=%h",
                         $time, rd_valid, rd_data, exp_valid, exp_data);
            end
        end
    end

    task automatic chk(string tag, logic [72:0] act, logic [72:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(logic [3:0] a, logic [71:0] exp, string tag);
        @(negedge clk); rd_req = 1; rd_addr = a;
        @(negedge clk); rd_req = 0;
        @(negedge clk); chk(tag, {rd_valid, rd_data}, {1'b1, exp});
    endtask

    task automatic do_write(logic [3:0] a, logic [71:0] d, logic [7:0] l);
        @(negedge clk); wr_req = 1; wr_addr = a;
        @(negedge clk); wr_req = 0;
        wa_data = d[17:0];  wa_lanes = l[1:0]; wb_data = d[35:18]; wb_lanes = l[3:2];
        @(negedge clk);
        wa_data = d[53:36]; wa_lanes = l[5:4]; wb_data = d[71:54]; wb_lanes = l[7:6];
        @(negedge clk); wa_lanes = 0; wb_lanes = 0; wa_data = 0; wb_data = 0;
    endtask

    localparam logic [71:0] W_A = {18'h01234, 18'h3C3C3, 18'h15555, 18'h0AAAA};
    localparam logic [71:0] W_B = {18'h2F0F0, 18'h00F0F, 18'h1ABCD, 18'h3FE01};

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_valid low in reset", {72'h0, rd_valid}, 73'h0);
        rst_n = 1;
        model_on = 1;
        rd_chk(4'd3, 72'h0, "R1 cleared word");

        // R3: full burst, beat order
        do_write(4'd2, W_A, 8'hFF);
        rd_chk(4'd2, W_A, "R3 beat order");

        // R5: per-beat lane enables 01,10,00,11
        do_write(4'd2, {4{18'h3FFFF}}, 8'b11_00_10_01);
        rd_chk(4'd2, {18'h3FFFF, W_A[53:36], 9'h1FF, W_A[26:18], W_A[17:9], 9'h1FF},
               "R5 lane mask");

        // R4: request one edge after an accepted one is dropped
        @(negedge clk); wr_req = 1; wr_addr = 4'd4;
        @(negedge clk); wr_addr = 4'd5;
        wa_data = W_B[17:0]; wb_data = W_B[35:18]; wa_lanes = 3; wb_lanes = 3;
        @(negedge clk); wr_req = 0;
        wa_data = W_B[53:36]; wb_data = W_B[71:54];
        @(negedge clk); wa_lanes = 0; wb_lanes = 0;
        rd_chk(4'd4, W_B, "R4 first burst kept");
        rd_chk(4'd5, 72'h0, "R4 second request ignored");

        // R2: bursts two cycles apart
        @(negedge clk); wr_req = 1; wr_addr = 4'd7;
        @(negedge clk); wr_req = 0;
        wa_data = W_A[17:0]; wb_data = W_A[35:18]; wa_lanes = 3; wb_lanes = 3;
        @(negedge clk); wr_req = 1; wr_addr = 4'd8;
        wa_data = W_A[53:36]; wb_data = W_A[71:54];
        @(negedge clk); wr_req = 0;
        wa_data = W_B[17:0]; wb_data = W_B[35:18];
        @(negedge clk); wa_data = W_B[53:36]; wb_data = W_B[71:54];
        @(negedge clk); wa_lanes = 0; wb_lanes = 0;
        rd_chk(4'd7, W_A, "R2 first of pair");
        rd_chk(4'd8, W_B, "R2 second of pair");

        // R8: beats outside a burst are ignored
        @(negedge clk); wa_data = 18'h3FFFF; wb_data = 18'h3FFFF; wa_lanes = 3; wb_lanes = 3;
        repeat (4) @(negedge clk);
        wa_lanes = 0; wb_lanes = 0;
        rd_chk(4'd7, W_A, "R8 idle beats ignored");

        // R9 and R7: reads at the accept edge and one edge later
        do_write(4'd6, W_B, 8'hFF);
        @(negedge clk); wr_req = 1; wr_addr = 4'd6; rd_req = 1; rd_addr = 4'd6;
        @(negedge clk); wr_req = 0;
        wa_data = W_A[17:0]; wa_lanes = 2'b01; wb_data = W_A[35:18]; wb_lanes = 2'b11;
        @(negedge clk); rd_req = 0;
        wa_data = W_A[53:36]; wa_lanes = 2'b00; wb_data = W_A[71:54]; wb_lanes = 2'b10;
        chk("R9 read at accept edge", {rd_valid, rd_data}, {1'b1, W_B});
        @(negedge clk); wa_lanes = 0; wb_lanes = 0;
        chk("R7 forwarded merge", {rd_valid, rd_data},
            {1'b1, W_A[71:63], W_B[62:36], W_A[35:18], W_B[17:9], W_A[8:0]});
        rd_chk(4'd6, {W_A[71:63], W_B[62:36], W_A[35:18], W_B[17:9], W_A[8:0]},
               "R7 stored after merge");

        // Dense random traffic on four addresses, checked by the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            wr_req = $urandom_range(0, 1); wr_addr = 4'($urandom_range(0, 3));
            wa_data = 18'($urandom); wb_data = 18'($urandom);
            wa_lanes = 2'($urandom); wb_lanes = 2'($urandom);
            rd_req = $urandom_range(0, 1); rd_addr = 4'($urandom_range(0, 3));
        end
        @(negedge clk); wr_req = 0; rd_req = 0;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule